// File: doc/BRIEF.md
# Six-Request Vectored Interrupt Controller

This block gathers nine raw event sources into six interrupt requests and offers one of them at a time to a processor core. Three asynchronous external pins each go through a two-stage synchronizer and an edge detector. Two of these pins detect both edges and share their request with an analog comparator event. The third pin detects only falling edges. Two timer events each own a request. The last request takes either a low-voltage flag or a timer end-of-count pulse, depending on a select input.

Each detected event sets a pending bit. A mask register decides which pending bits may be offered. A 3-bit priority code picks one of eight fixed orderings, and the highest-ranked unmasked pending request wins. The block drives a request line, the index of the winning request and the address of its two-byte vector slot. A one-cycle acknowledge clears the pending bit of the request on offer. Software reads and writes the pending, mask and priority registers over a small register bus.

Top module: `irq_hub6`

## Requirements
- R1: After a synchronous active-low reset, the pending, mask and priority registers read 0 and `irq_req_o` is low.
- R2: Pending bit 0 is set by either edge of `ext_pin_i[0]` or by a rising edge of `cmp_evt_i[0]`. A pin change made before clock edge k shows in the pending register after edge k+2.
- R3: Pending bit 1 is set only by a falling edge of `ext_pin_i[1]`. A rising edge of that pin sets nothing.
- R4: Pending bit 2 is set by either edge of `ext_pin_i[2]` or by a rising edge of `cmp_evt_i[1]`.
- R5: A rising edge of `tmr16_evt_i` sets pending bit 3, and a rising edge of `tmr8_evt_i` sets pending bit 4, both after the next clock edge. An input held high sets its bit only once.
- R6: When `lowbat_en_i` is 1, only a rising edge of `lowbat_flag_i` sets pending bit 5. When it is 0, only a rising edge of `tmr1_eoc_i` sets it.
- R7: A mask bit of 1 lets the matching pending bit be offered. A pending bit whose mask bit is 0 stays pending, but it is never offered.
- R8: Priority code c (bits 2:0) builds an order in which rank p holds request (p + c[1:0]) mod 6. When c[2] is 1, that order is reversed. The lowest rank among the unmasked pending requests wins, and code 0 gives request 0 the top rank.
- R9: While `irq_req_o` is high, `irq_id_o` holds the winning request n and `irq_vec_o` holds 2n, the first of its two vector bytes at 2n and 2n+1.
- R10: `irq_ack_i` high for one cycle while a request is on offer clears that request's pending bit. A new event for the same bit in the same cycle keeps the bit set.
- R11: On the register bus, address 0 is the pending register (a write replaces all six bits), address 1 is the mask (bits 5:0) and address 2 is the priority code (bits 2:0). Address 3 reads 0, and unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 3 | Asynchronous external interrupt pins |
| cmp_evt_i | input | 2 | Comparator events, bit 0 to request 0 and bit 1 to request 2 |
| tmr16_evt_i | input | 1 | 16-bit timer event |
| tmr8_evt_i | input | 1 | 8-bit timer event |
| tmr1_eoc_i | input | 1 | Timer end-of-count pulse for request 5 |
| lowbat_flag_i | input | 1 | Low-voltage flag for request 5 |
| lowbat_en_i | input | 1 | Selects the low-voltage flag as the request 5 source |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data, combinational from the address |
| irq_ack_i | input | 1 | Acknowledge of the request on offer |
| irq_req_o | output | 1 | An unmasked request is pending |
| irq_id_o | output | 3 | Index of the winning request |
| irq_vec_o | output | 8 | Vector address of the winning request |

## Verification
Each pin is toggled in both directions. This separates the both-edge pins from the falling-only pin, and a read before the third clock edge shows that the synchronizer latency is right. Comparator, timer and low-voltage inputs are held high across several cycles to show that a level fires once, and request 5 is driven from both of its sources under each select value. The resolver is tried with all eight priority codes against a full pending set and two sparse pending sets, so that rotation, reversal and skipping of empty ranks are all told apart. A behavioural reference model is compared with the request, index and vector outputs on every clock. Acknowledge is tried alone and together with a same-cycle event on the bit it clears.

// File: rtl/irq_hub_pkg.sv
// Shared constants, types and the priority ordering function for the
// six-request interrupt controller.
package irq_hub_pkg;

    localparam int NUM_IRQ = 6;
    localparam int ID_W    = 3;
    localparam int PRIO_W  = 3;
    localparam int ADDR_W  = 2;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2
    } edge_kind_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_PEND = 2'd0,
        RA_MASK = 2'd1,
        RA_PRIO = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    // Request index that holds rank pos (0 = highest) under priority code.
    function automatic logic [ID_W-1:0] rank_to_irq(input logic [PRIO_W-1:0] code,
                                                    input int pos);
        int step;
        int slot;
        step = int'(code[1:0]);
        slot = code[2] ? (NUM_IRQ - 1 - pos) : pos;
        return ID_W'((slot + step) % NUM_IRQ);
    endfunction

endpackage

// File: rtl/irq_edge_det.sv
// Optional synchronizer chain followed by an edge detector.
// Assumes: STAGES = 0 only for inputs already synchronous to clk.
// Emits a one-cycle event for each qualifying edge of the (synchronized) level.
module irq_edge_det
    import irq_hub_pkg::*;
#(
    parameter int         STAGES = 2,
    parameter edge_kind_e KIND   = EDGE_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic evt_o
);

    logic level;
    logic level_d;

    generate
        if (STAGES == 0) begin : g_direct
            assign level = sig_i;
        end else begin : g_sync
            logic [STAGES-1:0] chain;
            // Shift the asynchronous input through the synchronizer stages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain[0] <= sig_i;
                    for (int i = 1; i < STAGES; i++) begin
                        chain[i] <= chain[i-1];
                    end
                end
            end
            assign level = chain[STAGES-1];
        end
    endgenerate

    // Remember the previous level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    generate
        if (KIND == EDGE_RISE) begin : g_rise
            assign evt_o = level & ~level_d;
        end else if (KIND == EDGE_FALL) begin : g_fall
            assign evt_o = ~level & level_d;
        end else begin : g_both
            assign evt_o = level ^ level_d;
        end

        if (KIND != EDGE_BOTH) begin : g_chk
            // R5: a single-direction detector never fires twice in a row.
            a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
                evt_o |=> !evt_o);
        end
    endgenerate

endmodule

// File: rtl/irq_src_map.sv
// Maps the nine raw sources onto six set-event lines.
// Assumes: pins are asynchronous; comparator, timer and low-voltage inputs are
// synchronous levels or pulses. Request 5 is selected per event by lowbat_en_i.
module irq_src_map
    import irq_hub_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         ext_pin_i,
    input  logic [1:0]         cmp_evt_i,
    input  logic               tmr16_evt_i,
    input  logic               tmr8_evt_i,
    input  logic               tmr1_eoc_i,
    input  logic               lowbat_flag_i,
    input  logic               lowbat_en_i,
    output logic [NUM_IRQ-1:0] set_o
);

    logic [2:0] pin_ev;
    logic [1:0] cmp_ev;
    logic       t16_ev;
    logic       t8_ev;
    logic       t1_ev;
    logic       lb_ev;

    generate
        for (genvar i = 0; i < 3; i++) begin : g_pin
            localparam edge_kind_e PK = (i == 1) ? EDGE_FALL : EDGE_BOTH;
            irq_edge_det #(.STAGES(SYNC_STAGES), .KIND(PK)) u_pin (
                .clk(clk), .rst_n(rst_n), .sig_i(ext_pin_i[i]), .evt_o(pin_ev[i]));
        end
        for (genvar j = 0; j < 2; j++) begin : g_cmp
            irq_edge_det #(.STAGES(0), .KIND(EDGE_RISE)) u_cmp (
                .clk(clk), .rst_n(rst_n), .sig_i(cmp_evt_i[j]), .evt_o(cmp_ev[j]));
        end
    endgenerate

    irq_edge_det #(.STAGES(0), .KIND(EDGE_RISE)) u_t16 (
        .clk(clk), .rst_n(rst_n), .sig_i(tmr16_evt_i), .evt_o(t16_ev));
    irq_edge_det #(.STAGES(0), .KIND(EDGE_RISE)) u_t8 (
        .clk(clk), .rst_n(rst_n), .sig_i(tmr8_evt_i), .evt_o(t8_ev));
    irq_edge_det #(.STAGES(0), .KIND(EDGE_RISE)) u_t1 (
        .clk(clk), .rst_n(rst_n), .sig_i(tmr1_eoc_i), .evt_o(t1_ev));
    irq_edge_det #(.STAGES(0), .KIND(EDGE_RISE)) u_lb (
        .clk(clk), .rst_n(rst_n), .sig_i(lowbat_flag_i), .evt_o(lb_ev));

    // Merge shared sources into the six request set lines.
    always_comb begin
        set_o[0] = pin_ev[0] | cmp_ev[0];
        set_o[1] = pin_ev[1];
        set_o[2] = pin_ev[2] | cmp_ev[1];
        set_o[3] = t16_ev;
        set_o[4] = t8_ev;
        set_o[5] = lowbat_en_i ? lb_ev : t1_ev;
    end

    // R6: with the low-voltage source selected, only its edge sets request 5.
    a_r6_lowbat_only: assert property (@(posedge clk) disable iff (!rst_n)
        (lowbat_en_i && !lb_ev) |-> !set_o[5]);

endmodule

// File: rtl/irq_reg_file.sv
// Pending, mask and priority registers with a simple register bus.
// Assumes: single-cycle writes; read data is combinational from the address.
// Pending update order: bus write, else acknowledge clear, then new events OR in.
module irq_reg_file
    import irq_hub_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [NUM_IRQ-1:0] set_i,
    input  logic               ack_i,
    input  logic               req_i,
    input  logic [ID_W-1:0]    id_i,
    output logic [NUM_IRQ-1:0] pend_o,
    output logic [NUM_IRQ-1:0] mask_o,
    output logic [PRIO_W-1:0]  prio_o
);

    localparam int PAD_P = DATA_W - NUM_IRQ;
    localparam int PAD_C = DATA_W - PRIO_W;

    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] pend_nx;
    logic [NUM_IRQ-1:0] mask_q;
    logic [PRIO_W-1:0]  prio_q;
    logic               wr_pend;
    logic               unused_wbits;

    assign wr_pend      = we_i && (addr_i == RA_PEND);
    assign unused_wbits = ^wdata_i[DATA_W-1:NUM_IRQ];

    // Next pending value: write, else acknowledge clear, then events.
    always_comb begin
        pend_nx = pend_q;
        if (wr_pend) begin
            pend_nx = wdata_i[NUM_IRQ-1:0];
        end else if (ack_i && req_i) begin
            pend_nx[id_i] = 1'b0;
        end
        pend_nx = pend_nx | set_i;
    end

    // Register the pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nx;
    end

    // Register the mask and priority code from bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            prio_q <= '0;
        end else if (we_i) begin
            if (addr_i == RA_MASK) mask_q <= wdata_i[NUM_IRQ-1:0];
            if (addr_i == RA_PRIO) prio_q <= wdata_i[PRIO_W-1:0];
        end
    end

    // Return the addressed register, zero-padded.
    always_comb begin
        case (addr_i)
            RA_PEND: rdata_o = {{PAD_P{1'b0}}, pend_q};
            RA_MASK: rdata_o = {{PAD_P{1'b0}}, mask_q};
            RA_PRIO: rdata_o = {{PAD_C{1'b0}}, prio_q};
            default: rdata_o = '0;
        endcase
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
    assign prio_o = prio_q;

    // R1: reset leaves all registers cleared.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && mask_q == '0 && prio_q == '0));

    // R10: an acknowledge with no competing write or event clears the bit.
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_i && !wr_pend && !set_i[id_i]) |=> !pend_q[$past(id_i)]);

    // R7: pending bits are never lost without a write or acknowledge.
    a_r7_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !wr_pend) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: rtl/irq_prio_pick.sv
// Priority resolver: picks the highest-ranked active request under the code.
// Assumes: active_i is already masked. clk/rst_n clock only the checks.
module irq_prio_pick
    import irq_hub_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] active_i,
    input  logic [PRIO_W-1:0]  code_i,
    output logic               req_o,
    output logic [ID_W-1:0]    id_o,
    output logic [VEC_W-1:0]   vec_o
);

    // Walk ranks from lowest to highest so the highest active one is kept.
    always_comb begin
        logic [ID_W-1:0] cand;
        req_o = 1'b0;
        id_o  = '0;
        cand  = '0;
        for (int p = NUM_IRQ - 1; p >= 0; p--) begin
            cand = rank_to_irq(code_i, p);
            if (active_i[cand]) begin
                req_o = 1'b1;
                id_o  = cand;
            end
        end
    end

    // Vector slot start is twice the request index.
    assign vec_o = VEC_W'({id_o, 1'b0});

    // R8: the offered request is active.
    a_r8_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> active_i[id_o]);

    // R8: nothing is offered when nothing is active.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i == '0) |-> !req_o);

endmodule

// File: rtl/irq_hub6.sv
// Top of the six-request vectored interrupt controller.
// Assumes: a core takes irq_id_o/irq_vec_o while irq_req_o is high and pulses
// irq_ack_i for one cycle. Outputs depend only on registered state.
module irq_hub6
    import irq_hub_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8,
    parameter int VEC_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        ext_pin_i,
    input  logic [1:0]        cmp_evt_i,
    input  logic              tmr16_evt_i,
    input  logic              tmr8_evt_i,
    input  logic              tmr1_eoc_i,
    input  logic              lowbat_flag_i,
    input  logic              lowbat_en_i,
    input  logic              bus_we_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              irq_ack_i,
    output logic              irq_req_o,
    output logic [2:0]        irq_id_o,
    output logic [VEC_W-1:0]  irq_vec_o
);

    logic [NUM_IRQ-1:0] set_ev;
    logic [NUM_IRQ-1:0] pend;
    logic [NUM_IRQ-1:0] mask;
    logic [PRIO_W-1:0]  prio;
    logic [NUM_IRQ-1:0] active;

    irq_src_map #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk(clk), .rst_n(rst_n),
        .ext_pin_i(ext_pin_i), .cmp_evt_i(cmp_evt_i),
        .tmr16_evt_i(tmr16_evt_i), .tmr8_evt_i(tmr8_evt_i),
        .tmr1_eoc_i(tmr1_eoc_i), .lowbat_flag_i(lowbat_flag_i),
        .lowbat_en_i(lowbat_en_i), .set_o(set_ev));

    irq_reg_file #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
        .rdata_o(bus_rdata_o), .set_i(set_ev), .ack_i(irq_ack_i),
        .req_i(irq_req_o), .id_i(irq_id_o),
        .pend_o(pend), .mask_o(mask), .prio_o(prio));

    // Only unmasked pending requests compete.
    assign active = pend & mask;

    irq_prio_pick #(.VEC_W(VEC_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .active_i(active), .code_i(prio),
        .req_o(irq_req_o), .id_o(irq_id_o), .vec_o(irq_vec_o));

    // R7: an offered request always has its mask bit set.
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> mask[irq_id_o]);

endmodule

// File: tb/sim_irq_hub6.sv
// Self-checking bench with a behavioural reference model compared every clock.
module sim_irq_hub6;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ext_pin = '0;
    logic [1:0] cmp_evt = '0;
    logic       tmr16 = 1'b0, tmr8 = 1'b0, tmr1 = 1'b0;
    logic       lowbat = 1'b0, lowbat_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ack = 1'b0;
    logic       irq_req;
    logic [2:0] irq_id;
    logic [7:0] irq_vec;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 0;
    bit  model_live = 0;

    irq_hub6 u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .cmp_evt_i(cmp_evt),
        .tmr16_evt_i(tmr16), .tmr8_evt_i(tmr8), .tmr1_eoc_i(tmr1),
        .lowbat_flag_i(lowbat), .lowbat_en_i(lowbat_en),
        .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .irq_ack_i(ack), .irq_req_o(irq_req),
        .irq_id_o(irq_id), .irq_vec_o(irq_vec));

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference ordering: rotate by code[1:0], reverse when code[2] is set.
    function automatic int ref_winner(bit [5:0] act, bit [2:0] code);
        int ord[$];
        for (int i = 0; i < 6; i++) ord.push_back((i + int'(code[1:0])) % 6);
        if (code[2]) ord.reverse();
        foreach (ord[k]) if (act[ord[k]]) return ord[k];
        return -1;
    endfunction

    // Behavioural model state.
    bit [2:0] m_s1, m_s2, m_s3;
    bit [1:0] m_cprev;
    bit       m_t16p, m_t8p, m_t1p, m_lbp;
    bit [5:0] m_pend, m_mask;
    bit [2:0] m_prio;

    always @(posedge clk) begin
        bit [5:0] e;
        bit [5:0] np;
        int       w;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_cprev = '0;
            m_t16p = 0; m_t8p = 0; m_t1p = 0; m_lbp = 0;
            m_pend = '0; m_mask = '0; m_prio = '0;
        end else begin
            e[0] = (m_s2[0] != m_s3[0]) || (cmp_evt[0] && !m_cprev[0]);
            e[1] = m_s3[1] && !m_s2[1];
            e[2] = (m_s2[2] != m_s3[2]) || (cmp_evt[1] && !m_cprev[1]);
            e[3] = tmr16 && !m_t16p;
            e[4] = tmr8 && !m_t8p;
            e[5] = lowbat_en ? (lowbat && !m_lbp) : (tmr1 && !m_t1p);
            w  = ref_winner(m_pend & m_mask, m_prio);
            np = m_pend;
            if (bus_we && bus_addr == 2'd0) np = bus_wdata[5:0];
            else if (ack && w >= 0) np[w] = 1'b0;
            np = np | e;
            if (bus_we && bus_addr == 2'd1) m_mask = bus_wdata[5:0];
            if (bus_we && bus_addr == 2'd2) m_prio = bus_wdata[2:0];
            m_pend = np;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
            m_cprev = cmp_evt; m_t16p = tmr16; m_t8p = tmr8;
            m_t1p = tmr1; m_lbp = lowbat;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R8, R9).
    always @(negedge clk) begin
        int w;
        if (rst_n && model_live && !done) begin
            w = ref_winner(m_pend & m_mask, m_prio);
            chk(irq_req == (w >= 0), "R8 req vs model", int'(irq_req), int'(w >= 0));
            if (w >= 0) begin
                chk(int'(irq_id) == w, "R8 id vs model", int'(irq_id), w);
                chk(int'(irq_vec) == 2 * w, "R9 vector vs model", int'(irq_vec), 2 * w);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit [1:0] a, input bit [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdchk(input bit [1:0] a, input int exp, input string tag);
        bus_addr = a;
        #1;
        chk(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
    endtask

    initial begin
        bit [5:0] pats[3];
        pats[0] = 6'h3F; pats[1] = 6'h12; pats[2] = 6'h21;
        tick(4);
        rst_n = 1'b1;
        model_live = 1;
        tick(1);
        // R1 reset state
        rdchk(0, 0, "R1 pending after reset");
        rdchk(1, 0, "R1 mask after reset");
        rdchk(2, 0, "R1 prio after reset");
        chk(irq_req == 1'b0, "R1 req after reset", int'(irq_req), 0);
        // R11 bus map
        wr(1, 8'hFF);
        rdchk(1, 8'h3F, "R11 mask readback");
        rdchk(3, 0, "R11 address 3");
        wr(2, 8'hFD);
        rdchk(2, 5, "R11 prio readback");
        wr(2, 0);
        // R2 both edges on pin 0, latency, comparator
        ext_pin[0] = 1'b1;
        tick(2);
        rdchk(0, 0, "R2 not before third edge");
        tick(1);
        rdchk(0, 1, "R2 rising pin0");
        chk(irq_req && irq_id == 3'd0, "R2 req id 0", int'(irq_id), 0);
        wr(0, 0);
        ext_pin[0] = 1'b0;
        tick(3);
        rdchk(0, 1, "R2 falling pin0");
        wr(0, 0);
        cmp_evt[0] = 1'b1;
        tick(1);
        rdchk(0, 1, "R2 comparator 0");
        wr(0, 0);
        tick(2);
        rdchk(0, 0, "R2 held comparator fires once");
        cmp_evt[0] = 1'b0;
        // R3 falling only
        ext_pin[1] = 1'b1;
        tick(4);
        rdchk(0, 0, "R3 rising pin1 ignored");
        ext_pin[1] = 1'b0;
        tick(3);
        rdchk(0, 2, "R3 falling pin1");
        // R4 pin 2 both edges and comparator 1
        wr(0, 0);
        ext_pin[2] = 1'b1;
        tick(3);
        rdchk(0, 4, "R4 rising pin2");
        wr(0, 0);
        ext_pin[2] = 1'b0;
        tick(3);
        rdchk(0, 4, "R4 falling pin2");
        wr(0, 0);
        cmp_evt[1] = 1'b1;
        tick(1);
        rdchk(0, 4, "R4 comparator 1");
        cmp_evt[1] = 1'b0;
        // R5 timers
        wr(0, 0);
        tmr16 = 1'b1;
        tick(1);
        rdchk(0, 8, "R5 timer16");
        wr(0, 0);
        tick(2);
        rdchk(0, 0, "R5 held timer16 fires once");
        tmr16 = 1'b0;
        tmr8 = 1'b1;
        tick(1);
        rdchk(0, 16, "R5 timer8");
        tmr8 = 1'b0;
        // R6 request 5 source select
        wr(0, 0);
        lowbat_en = 1'b1;
        tmr1 = 1'b1;
        tick(1);
        tmr1 = 1'b0;
        tick(1);
        rdchk(0, 0, "R6 timer1 ignored when low-voltage selected");
        lowbat = 1'b1;
        tick(1);
        rdchk(0, 32, "R6 low-voltage flag");
        lowbat = 1'b0;
        wr(0, 0);
        lowbat_en = 1'b0;
        tmr1 = 1'b1;
        tick(1);
        rdchk(0, 32, "R6 timer1 when deselected");
        tmr1 = 1'b0;
        wr(0, 0);
        lowbat = 1'b1;
        tick(1);
        rdchk(0, 0, "R6 low-voltage ignored when deselected");
        lowbat = 1'b0;
        // R7 masking
        wr(1, 0);
        wr(0, 8'h3F);
        chk(irq_req == 1'b0, "R7 all masked no req", int'(irq_req), 0);
        rdchk(0, 63, "R7 masked still pending");
        wr(1, 8'h20);
        chk(irq_req && irq_id == 3'd5, "R7 only unmasked offered", int'(irq_id), 5);
        // R8/R9 all priority codes
        wr(1, 8'h3F);
        for (int c = 0; c < 8; c++) begin
            wr(2, 8'(c));
            for (int k = 0; k < 3; k++) begin
                int w;
                wr(0, {2'b00, pats[k]});
                w = ref_winner(pats[k], 3'(c));
                chk(int'(irq_id) == w, "R8 priority code winner", int'(irq_id), w);
                chk(int'(irq_vec) == 2 * w, "R9 vector of winner", int'(irq_vec), 2 * w);
            end
        end
        wr(2, 0);
        wr(0, 0);
        chk(int'(irq_id) == 0 || !irq_req, "R8 idle", int'(irq_req), 0);
        wr(2, 4);
        wr(0, 8'h3F);
        chk(irq_id == 3'd5, "R8 code 4 puts request 5 first", int'(irq_id), 5);
        // R10 acknowledge
        wr(2, 0);
        wr(0, 3);
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        rdchk(0, 2, "R10 ack clears presented");
        chk(irq_id == 3'd1, "R10 next winner", int'(irq_id), 1);
        wr(0, 8);
        ack = 1'b1;
        tmr16 = 1'b1;
        tick(1);
        ack = 1'b0;
        tmr16 = 1'b0;
        rdchk(0, 8, "R10 same-cycle event wins");
        tick(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule